// File: doc/BRIEF.md
# Chip Select Burst Read Planner

This block sits between a cached processor bus and the external peripherals, each of which is reached through its own chip select. For every read request it picks how the read goes out on the external bus. The choices are a single access, a short burst of one 64-bit doubleword, a long burst of four doublewords, or a run of short bursts that covers a whole cache line. It then produces one beat address per clock until the transfer ends.

The choice depends on three things. The first is a global input that says whether the external bus is in a burst-capable mode. The second is the kind of read: a data read, an instruction fetch, an aligned line fill, or a line fill that wants its critical doubleword first. The third is three capability bits per chip select: bursting allowed, 32-byte bursts supported, and wrapped ordering supported. Requests made on the boot chip select use the capability bits of chip select 0.

A request is taken when `req_valid_i` and `req_ready_o` are both high. Beats then appear on consecutive cycles, and `done_o` marks the last beat. `req_ready_o` rises again only after that last beat.

Top module: `cs_burst_planner`

## Requirements
- R1: After reset, `req_ready_o` is 1 and both `beat_valid_o` and `done_o` are 0.
- R2: If `burst_mode_i` is 0, or the bursting-allowed bit of the selected chip select is 0, every request becomes one single access. That access has type 0 and wrap 0, and it goes out at the full request address. The 32-byte and wrap capability bits are ignored in this case.
- R3: A request of kind 0 (data read) always becomes one single access, with type 0 at the full request address.
- R4: With bursting allowed, a request of kind 1 (instruction fetch) becomes a short burst. That is type 1, one beat, at the doubleword-aligned request address.
- R5: With bursting allowed, a kind 2 request (aligned line fill) on a 32-byte capable chip select becomes a long burst. It has type 2 and wrap 0. Its four beats run from the 32-byte line base upward in steps of 8 bytes.
- R6: A kind 2 request with bursting allowed but no 32-byte support becomes four short bursts. They have type 1 and run from the line base upward, and `beat_first_o` is 1 on every beat.
- R7: With bursting allowed, a kind 3 request (critical doubleword first) on a chip select with both 32-byte and wrap support becomes a long wrapping burst. It has type 2 and wrap 1. Its four beats start at the requested doubleword, and address bits [4:3] step up modulo 4.
- R8: A kind 3 request with bursting allowed that lacks 32-byte or wrap support becomes four short bursts. They have type 1 and wrap 0, follow the same critical-first wrapped order, and assert `beat_first_o` on every beat.
- R9: When `req_boot_i` is 1, the capability bits of chip select 0 decide the plan, whatever `req_cs_i` holds.
- R10: Beats appear on consecutive cycles, the first in the cycle after acceptance. `done_o` is 1 on the last beat only. `req_ready_o` stays 0 from acceptance through the last beat, and a request presented in that time is not taken.
- R11: Within a burst, `beat_first_o` is 1 on the first beat and 0 on the later beats of a long burst. Beat addresses of any burst have bits [2:0] equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_mode_i | input | 1 | External bus is in a burst-capable mode |
| cfg_bre_i | input | NUM_CS | Per chip select: bursting allowed |
| cfg_long_i | input | NUM_CS | Per chip select: 32-byte bursts supported |
| cfg_wrap_i | input | NUM_CS | Per chip select: wrapped ordering supported |
| req_valid_i | input | 1 | Read request present |
| req_boot_i | input | 1 | Request targets the boot chip select |
| req_cs_i | input | CS_W | Chip select of the request |
| req_kind_i | input | 2 | 0 data, 1 fetch, 2 aligned line, 3 critical first |
| req_addr_i | input | ADDR_W | Byte address of the request |
| req_ready_o | output | 1 | Block is idle and takes a request |
| plan_type_o | output | 2 | 0 single, 1 short, 2 long; valid with beats |
| plan_wrap_o | output | 1 | Long burst uses wrapped order |
| beat_valid_o | output | 1 | A beat is issued this cycle |
| beat_first_o | output | 1 | Beat opens a new burst |
| beat_addr_o | output | ADDR_W | Address of the current beat |
| done_o | output | 1 | Final beat of the transfer |

## Verification
Several corner cases are targeted directly. In the wrap fallback, a critical-first fill with 32-byte support but no wrap support must fall back to short bursts. A design that checks only the 32-byte bit would instead emit a wrapping long burst on a peripheral that cannot wrap. Two address cases are also covered. A critical doubleword at index 2 must produce the order 2, 3, 0, 1, and a line fill with an offset inside the line must start at the line base; an adder that carries into the line address, or a loss of the base alignment, shows up as a wrong beat address. The boot override is tested with chip select 0 and the named chip select set up in opposite ways, and a request held high across the final beat checks that nothing is accepted on the edge where `done_o` is high.

// File: rtl/cs_burst_pkg.sv
package cs_burst_pkg;

  typedef enum logic [1:0] {
    KIND_DATA  = 2'd0,
    KIND_FETCH = 2'd1,
    KIND_LINE  = 2'd2,
    KIND_CRIT  = 2'd3
  } rd_kind_e;

  typedef enum logic [1:0] {
    XFER_SINGLE = 2'd0,
    XFER_SHORT  = 2'd1,
    XFER_LONG   = 2'd2
  } xfer_e;

  // capabilities of one chip select
  typedef struct packed {
    logic bre;   // bursting allowed
    logic lng;   // 32-byte bursts supported
    logic wrp;   // wrapped ordering supported
  } cs_caps_t;

  // transfer plan for one request
  typedef struct packed {
    xfer_e xtype;
    logic  wrap;       // long burst in wrapped order
    logic  multi;      // covers a full line
    logic  split;      // line issued as separate short bursts
    logic  from_base;  // order starts at line base
  } plan_t;

endpackage

// File: rtl/cs_cfg_select.sv
module cs_cfg_select
  import cs_burst_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic [NUM_CS-1:0] bre_i,
  input  logic [NUM_CS-1:0] lng_i,
  input  logic [NUM_CS-1:0] wrp_i,
  input  logic [CS_W-1:0]   cs_i,
  input  logic              boot_i,
  output cs_caps_t          caps_o
);

  cs_caps_t caps_arr [NUM_CS];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_caps
    assign caps_arr[g].bre = bre_i[g];
    assign caps_arr[g].lng = lng_i[g];
    assign caps_arr[g].wrp = wrp_i[g];
  end

  // boot select borrows chip select 0 settings
  logic [CS_W-1:0] sel;
  assign sel = boot_i ? '0 : cs_i;

  always_comb begin
    caps_o = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (sel == CS_W'(i)) caps_o = caps_arr[i];
    end
  end

endmodule

// File: rtl/cs_burst_decide.sv
module cs_burst_decide
  import cs_burst_pkg::*;
(
  input  logic       burst_mode_i,
  input  cs_caps_t   caps_i,
  input  logic [1:0] kind_i,
  output plan_t      plan_o
);

  rd_kind_e kind;
  logic     burst_on;

  assign kind     = rd_kind_e'(kind_i);
  assign burst_on = burst_mode_i & caps_i.bre;

  always_comb begin
    plan_o.xtype     = XFER_SINGLE;
    plan_o.wrap      = 1'b0;
    plan_o.multi     = 1'b0;
    plan_o.split     = 1'b0;
    plan_o.from_base = 1'b0;
    if (burst_on) begin
      unique case (kind)
        KIND_FETCH: begin
          plan_o.xtype = XFER_SHORT;
        end
        KIND_LINE: begin
          plan_o.multi     = 1'b1;
          plan_o.from_base = 1'b1;
          if (caps_i.lng) begin
            plan_o.xtype = XFER_LONG;
          end else begin
            plan_o.xtype = XFER_SHORT;
            plan_o.split = 1'b1;
          end
        end
        KIND_CRIT: begin
          plan_o.multi = 1'b1;
          if (caps_i.lng && caps_i.wrp) begin
            plan_o.xtype = XFER_LONG;
            plan_o.wrap  = 1'b1;
          end else begin
            plan_o.xtype = XFER_SHORT;
            plan_o.split = 1'b1;
          end
        end
        default: begin
          plan_o.xtype = XFER_SINGLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/cs_beat_seq.sv
module cs_beat_seq
  import cs_burst_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFS_W    = 3,
  parameter int IDX_W    = 2,
  localparam int LINE_OFS = OFS_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  plan_t             plan_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              busy_o,
  output logic [1:0]        ptype_o,
  output logic              wrap_o,
  output logic              first_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);

  logic                       busy_q, busy_d;
  plan_t                      plan_q, plan_d;
  logic [ADDR_W-LINE_OFS-1:0] hi_q, hi_d;
  logic [IDX_W-1:0]           start_q, start_d;
  logic [IDX_W-1:0]           cnt_q, cnt_d;
  logic [OFS_W-1:0]           lo_q, lo_d;
  logic                       last;
  logic                       ce;
  logic [IDX_W-1:0]           idx;

  assign last = !plan_q.multi || (cnt_q == {IDX_W{1'b1}});
  assign ce   = accept_i | busy_q;
  assign idx  = start_q + cnt_q;

  always_comb begin
    busy_d  = busy_q;
    plan_d  = plan_q;
    hi_d    = hi_q;
    start_d = start_q;
    cnt_d   = cnt_q;
    lo_d    = lo_q;
    if (accept_i) begin
      busy_d  = 1'b1;
      plan_d  = plan_i;
      hi_d    = addr_i[ADDR_W-1:LINE_OFS];
      start_d = plan_i.from_base ? '0 : addr_i[LINE_OFS-1:OFS_W];
      lo_d    = addr_i[OFS_W-1:0];
      cnt_d   = '0;
    end else if (busy_q) begin
      if (last) busy_d = 1'b0;
      else      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      plan_q  <= '0;
      hi_q    <= '0;
      start_q <= '0;
      cnt_q   <= '0;
      lo_q    <= '0;
    end else if (ce) begin
      busy_q  <= busy_d;
      plan_q  <= plan_d;
      hi_q    <= hi_d;
      start_q <= start_d;
      cnt_q   <= cnt_d;
      lo_q    <= lo_d;
    end
  end

  assign busy_o  = busy_q;
  assign ptype_o = plan_q.xtype;
  assign wrap_o  = plan_q.wrap;
  assign first_o = busy_q & ((cnt_q == '0) | plan_q.split);
  assign done_o  = busy_q & last;
  assign addr_o  = {hi_q, idx, (plan_q.xtype == XFER_SINGLE) ? lo_q : {OFS_W{1'b0}}};

  AST_DONE_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);                                          // R10
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !accept_i |=> !busy_o);                            // R10
  AST_NO_EARLY_END: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !done_o |=> busy_o && $stable(ptype_o) && $stable(wrap_o)); // R10
  AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |-> !busy_q);                                       // R10
  AST_FIRST_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |=> first_o);                                       // R11

endmodule

// File: rtl/cs_burst_planner.sv
module cs_burst_planner
  import cs_burst_pkg::*;
#(
  parameter int NUM_CS     = 8,
  parameter int ADDR_W     = 32,
  parameter int BEAT_BYTES = 8,
  parameter int LINE_BYTES = 32,
  localparam int CS_W      = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int OFS_W     = $clog2(BEAT_BYTES),
  localparam int IDX_W     = $clog2(LINE_BYTES / BEAT_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burst_mode_i,
  input  logic [NUM_CS-1:0] cfg_bre_i,
  input  logic [NUM_CS-1:0] cfg_long_i,
  input  logic [NUM_CS-1:0] cfg_wrap_i,
  input  logic              req_valid_i,
  input  logic              req_boot_i,
  input  logic [CS_W-1:0]   req_cs_i,
  input  logic [1:0]        req_kind_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic [1:0]        plan_type_o,
  output logic              plan_wrap_o,
  output logic              beat_valid_o,
  output logic              beat_first_o,
  output logic [ADDR_W-1:0] beat_addr_o,
  output logic              done_o
);

  // reset asserts at once, releases on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cs_caps_t caps;
  plan_t    plan;
  logic     busy;
  logic     accept;

  cs_cfg_select #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_sel (
    .bre_i  (cfg_bre_i),
    .lng_i  (cfg_long_i),
    .wrp_i  (cfg_wrap_i),
    .cs_i   (req_cs_i),
    .boot_i (req_boot_i),
    .caps_o (caps)
  );

  cs_burst_decide u_dec (
    .burst_mode_i (burst_mode_i),
    .caps_i       (caps),
    .kind_i       (req_kind_i),
    .plan_o       (plan)
  );

  assign req_ready_o = !busy;
  assign accept      = req_valid_i && req_ready_o && rst_int_n;
  assign beat_valid_o = busy;

  cs_beat_seq #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .accept_i (accept),
    .plan_i   (plan),
    .addr_i   (req_addr_i),
    .busy_o   (busy),
    .ptype_o  (plan_type_o),
    .wrap_o   (plan_wrap_o),
    .first_o  (beat_first_o),
    .addr_o   (beat_addr_o),
    .done_o   (done_o)
  );

  AST_OFF_SINGLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    accept && !burst_mode_i |=> plan_type_o == 2'd0 && done_o);        // R2
  AST_DATA_SINGLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    accept && req_kind_i == 2'd0 |=> plan_type_o == 2'd0);            // R3
  AST_WRAP_LONG: assert property (@(posedge clk) disable iff (!rst_int_n)
    beat_valid_o && plan_wrap_o |-> plan_type_o == 2'd2);             // R7
  AST_BURST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_int_n)
    beat_valid_o && plan_type_o != 2'd0 |-> beat_addr_o[OFS_W-1:0] == '0); // R11

endmodule

// File: tb/sim_cs_burst_planner.sv
module sim_cs_burst_planner;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        burst_mode;
  logic [7:0]  bre, lng, wrp;
  logic        req_valid, req_boot;
  logic [2:0]  req_cs;
  logic [1:0]  req_kind;
  logic [31:0] req_addr;
  logic        ready, wrap, bvalid, bfirst, done;
  logic [1:0]  ptype;
  logic [31:0] baddr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cs_burst_planner u0 (
    .clk(clk), .rst_n(rst_n), .burst_mode_i(burst_mode),
    .cfg_bre_i(bre), .cfg_long_i(lng), .cfg_wrap_i(wrp),
    .req_valid_i(req_valid), .req_boot_i(req_boot), .req_cs_i(req_cs),
    .req_kind_i(req_kind), .req_addr_i(req_addr),
    .req_ready_o(ready), .plan_type_o(ptype), .plan_wrap_o(wrap),
    .beat_valid_o(bvalid), .beat_first_o(bfirst), .beat_addr_o(baddr),
    .done_o(done)
  );

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(int cs, bit b, bit l, bit w);
    bre[cs] = b; lng[cs] = l; wrp[cs] = w;
  endtask

  // present a request for one edge; returns at the negedge after acceptance
  task automatic do_req(string req, int cs, bit boot, int kind, logic [31:0] addr);
    @(negedge clk);
    check(ready === 1'b1, req, "ready before request", {63'd0, ready}, 64'd1);
    req_valid = 1'b1; req_boot = boot; req_cs = 3'(cs);
    req_kind = 2'(kind); req_addr = addr;
    @(negedge clk);
    req_valid = 1'b0; req_boot = 1'b0;
  endtask

  // check n beats from the current negedge, then the idle cycle after
  task automatic expect_burst(string req, int typ, bit wr, int n, int start,
                              bit split, logic [31:0] addr);
    logic [31:0] line, ea;
    logic [36:0] act, exp;
    line = addr & ~32'h1F;
    for (int k = 0; k < n; k++) begin
      if (k > 0) @(negedge clk);
      ea  = (typ == 0) ? addr : line + 32'(((start + k) % 4) * 8);
      act = {bvalid, bfirst, done, wrap, ptype, baddr[30:0]};
      exp = {1'b1, (k == 0) || split, k == n - 1, wr, 2'(typ), ea[30:0]};
      check(act === exp && baddr[31] === ea[31], req, $sformatf("beat %0d", k),
            {27'd0, act}, {27'd0, exp});
    end
    @(negedge clk);
    check(bvalid === 1'b0 && ready === 1'b1 && done === 1'b0, req, "idle after done",
          {61'd0, bvalid, ready, done}, 64'b010);
  endtask

  task automatic t_reset;
    check(ready === 1'b1 && bvalid === 1'b0 && done === 1'b0, "R1", "reset state",
          {61'd0, ready, bvalid, done}, 64'b100);
  endtask

  task automatic t_mode_off;
    burst_mode = 1'b0; set_cfg(2, 1, 1, 1);
    do_req("R2", 2, 0, 3, 32'h1000_001B);
    expect_burst("R2", 0, 0, 1, 0, 0, 32'h1000_001B);
    burst_mode = 1'b1;
  endtask

  task automatic t_bre_off;
    set_cfg(3, 0, 1, 1);
    do_req("R2", 3, 0, 2, 32'h2000_0044);
    expect_burst("R2", 0, 0, 1, 0, 0, 32'h2000_0044);
  endtask

  task automatic t_data;
    set_cfg(1, 1, 1, 1);
    do_req("R3", 1, 0, 0, 32'h3000_002D);
    expect_burst("R3", 0, 0, 1, 0, 0, 32'h3000_002D);
  endtask

  task automatic t_fetch;
    set_cfg(1, 1, 1, 1);
    do_req("R4", 1, 0, 1, 32'h3000_012C);
    expect_burst("R4", 1, 0, 1, 1, 0, 32'h3000_012C);
  endtask

  task automatic t_line_long;
    set_cfg(4, 1, 1, 0);
    do_req("R5", 4, 0, 2, 32'h4000_0274);
    expect_burst("R5", 2, 0, 4, 0, 0, 32'h4000_0274);
  endtask

  task automatic t_line_short;
    set_cfg(5, 1, 0, 1);
    do_req("R6", 5, 0, 2, 32'h5FFF_FFE8);
    expect_burst("R6", 1, 0, 4, 0, 1, 32'h5FFF_FFE8);
  endtask

  task automatic t_crit_wrap;
    set_cfg(6, 1, 1, 1);
    do_req("R7", 6, 0, 3, 32'h6000_0F50);
    expect_burst("R7", 2, 1, 4, 2, 0, 32'h6000_0F50);
  endtask

  task automatic t_crit_fallback;
    set_cfg(4, 1, 1, 0);
    do_req("R8", 4, 0, 3, 32'h7000_0038);
    expect_burst("R8", 1, 0, 4, 3, 1, 32'h7000_0038);
    set_cfg(5, 1, 0, 1);
    do_req("R8", 5, 0, 3, 32'h7000_0150);
    expect_burst("R8", 1, 0, 4, 2, 1, 32'h7000_0150);
  endtask

  task automatic t_boot;
    set_cfg(0, 1, 1, 1); set_cfg(7, 0, 0, 0);
    do_req("R9", 7, 1, 3, 32'h0000_0108);
    expect_burst("R9", 2, 1, 4, 1, 0, 32'h0000_0108);
    set_cfg(0, 0, 1, 1); set_cfg(7, 1, 1, 1);
    do_req("R9", 7, 1, 2, 32'h0000_0210);
    expect_burst("R9", 0, 0, 1, 0, 0, 32'h0000_0210);
  endtask

  task automatic t_busy_ignore;
    logic [31:0] ea;
    set_cfg(6, 1, 1, 1);
    do_req("R10", 6, 0, 3, 32'h8000_0008);
    // hold a different request throughout the burst
    req_valid = 1'b1; req_cs = 3'd1; req_kind = 2'd0; req_addr = 32'h9000_0001;
    for (int k = 0; k < 4; k++) begin
      if (k > 0) @(negedge clk);
      ea = 32'h8000_0000 + 32'(((1 + k) % 4) * 8);
      check(bvalid === 1'b1 && ready === 1'b0 && baddr === ea && done === (k == 3),
            "R10", $sformatf("busy beat %0d", k), {27'd0, ready, done, baddr},
            {27'd0, 1'b0, k == 3, ea});
    end
    @(negedge clk);
    check(bvalid === 1'b0 && ready === 1'b1, "R10", "held request not taken on done edge",
          {62'd0, bvalid, ready}, 64'b01);
    req_valid = 1'b0;
    @(negedge clk);
    check(bvalid === 1'b0, "R10", "stays idle", {63'd0, bvalid}, 64'd0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; burst_mode = 1'b1;
    bre = '0; lng = '0; wrp = '0;
    req_valid = 1'b0; req_boot = 1'b0; req_cs = '0; req_kind = '0; req_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_mode_off();
    t_bre_off();
    t_data();
    t_fetch();
    t_line_long();
    t_line_short();
    t_crit_wrap();
    t_crit_fallback();
    t_boot();
    t_busy_ignore();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule